// File: doc/BRIEF.md
# FM Synthesizer Register Bus Interface

This block is the host-facing register front end of a four-channel FM sound generator. The host sees four byte-wide ports arranged as two banks. Each bank has an address port and a data port. Writing an address port latches a register address for that bank. Each later write to the paired data port stores its byte at that latched address in a shadow register file. The file holds per-operator parameters, per-channel parameters and two common registers. The synthesis core reads the contents of the file as parallel outputs.

The eleven-bit frequency number and its three-bit octave block span two bytes. The upper byte is written first and held in a staging latch. Only the write of the matching lower byte moves both halves into the active outputs, so the core never sees a half-updated pitch. A second set of frequency registers for extra slots behaves the same way. The read side has its own map. It returns a status byte, data for the square-wave generator, end flags from the sample-playback engine and a constant zero. All of these arrive from outside the block as plain inputs.

Top module: `fm_regif`

## Requirements
- R1: Each bank keeps its own address latch, cleared to zero by reset. Port index 0 is the bank 0 address port, 1 is the bank 0 data port, 2 is the bank 1 address port and 3 is the bank 1 data port. Every data write uses the address most recently written to that bank's address port, so repeated data writes without a new address all go to the same register.
- R2: Channel selection: in bank 0, address bits [1:0]=01 select channel 0 and 10 select channel 1. In bank 1 the same codes select channels 2 and 3. For per-operator registers, address bits [3:2] select operator 0 to 3, so the low nibbles 1,5,9,D and 2,6,A,E map to operators 0 to 3.
- R3: A write to an address with upper nibble 3 to 9 stores the byte in `op_cfg[ch][op][n-3]`, where n is the upper nibble.
- R4: A write to $A5/$A6 (upper frequency byte: bits [5:3] block, bits [2:0] frequency bits 10:8) changes no output. The next write to $A1/$A2 sets `fnum` to {staged bits [2:0], low byte} and `block` to staged bits [5:3]. Both outputs change together at the clock edge that takes the low write. The staged value is kept for later low writes.
- R5: The extra-slot pair works the same way: $AD/$AE are staged, and $A9/$AA commits them to `xfnum`/`xblock`.
- R6: A bank 0 write to $28 sets `key_on[ch]` to data bits [7:4], where bit 4 is operator 0 and bit 7 is operator 3. Data bits [2:0] choose the channel: 001 selects ch0, 010 selects ch1, 101 selects ch2 and 110 selects ch3. Any other code changes nothing.
- R7: A bank 0 write to $22 sets `lfo_enable` from data bit 3 and `lfo_rate` from data bits [2:0].
- R8: `busy` is high for exactly BUSY_CYCLES cycles after the clock edge of each data write. A data write while busy is high is still stored and restarts the count.
- R9: Reads: port 0 returns {busy, 00000, timer_flags[1], timer_flags[0]}. Port 1 returns `ssg_rdata`. Port 2 returns {adpcm_end[6], 0, adpcm_end[5:0]}. Port 3 returns $00.
- R10: Data writes to undecoded addresses change no output. This covers low-address codes 00 and 11, $Bx with address bit 3 set, and $22/$28 written through bank 1.
- R11: Synchronous reset clears every shadow register, staging latch, key state, address latch and the busy count.
- R12: A write to $B1/$B2 stores the byte in `ch_cfg[ch][0]`, and a write to $B5/$B6 stores it in `ch_cfg[ch][1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the selected port |
| bus_port | input | 2 | Port index 0 to 3 for both reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_port` (combinational) |
| timer_flags | input | 2 | Timer B (bit 1) and timer A (bit 0) flags, already gated by interrupt enable |
| ssg_rdata | input | 8 | Read-back byte from the square-wave generator |
| adpcm_end | input | 7 | Sample end flags: bit 6 for the second engine, bits 5:0 for channels, already masked |
| busy | output | 1 | Write-busy status |
| fnum | output | 4x11 | Active frequency number per channel |
| block | output | 4x3 | Active octave block per channel |
| xfnum | output | 4x11 | Active extra-slot frequency number per channel |
| xblock | output | 4x3 | Active extra-slot block per channel |
| key_on | output | 4x4 | Key state per channel and operator |
| lfo_enable | output | 1 | Low-frequency oscillator enable |
| lfo_rate | output | 3 | Low-frequency oscillator rate code |
| ch_cfg | output | 4x2x8 | Per-channel algorithm/feedback byte and pan/sensitivity byte |
| op_cfg | output | 4x4x7x8 | Per-operator parameter bytes, bases $30 to $90 |

## Verification
The assertions assume that `rst` is held high from time zero through at least one clock edge. They also assume that the bus carries at most one port write per cycle, which the single port index makes true. They assume that `bus_port` and `bus_wr` are valid at every sampled edge. The bench drives every input from a known value at the falling edge and never leaves the strobe undefined. Any output that is held stable is checked only across cycles with no data write, because address-port writes alone must not move any output.

// File: rtl/fm_regif_pkg.sv
package fm_regif_pkg;

    localparam int NUM_BANKS   = 2;
    localparam int NUM_CH      = 4;
    localparam int NUM_OPS     = 4;
    localparam int NUM_OPREGS  = 7;
    localparam int FNUM_W      = 11;
    localparam int BLK_W       = 3;
    localparam int CH_W        = $clog2(NUM_CH);
    localparam int OP_W        = $clog2(NUM_OPS);
    localparam int OPREG_W     = $clog2(NUM_OPREGS);

    typedef enum logic [1:0] {
        PORT_ADDR0 = 2'd0,
        PORT_DATA0 = 2'd1,
        PORT_ADDR1 = 2'd2,
        PORT_DATA1 = 2'd3
    } port_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_OP,
        TGT_FLO,
        TGT_FHI,
        TGT_XLO,
        TGT_XHI,
        TGT_CHCFG,
        TGT_COMMON
    } tgt_e;

    typedef struct packed {
        tgt_e                tgt;
        logic [CH_W-1:0]     ch;
        logic [OP_W-1:0]     op;
        logic [OPREG_W-1:0]  idx;
    } dec_t;

    typedef struct packed {
        logic            valid;
        logic [CH_W-1:0] ch;
    } keysel_t;

    // Map a bank and latched address to its register target.
    function automatic dec_t decode_addr(input logic bank, input logic [7:0] a);
        dec_t d;
        d = '0;
        d.tgt = TGT_NONE;
        if (!bank && a == 8'h22) begin
            d.tgt = TGT_COMMON;
            d.idx = 3'd0;
        end else if (!bank && a == 8'h28) begin
            d.tgt = TGT_COMMON;
            d.idx = 3'd1;
        end else if (a[1:0] == 2'b01 || a[1:0] == 2'b10) begin
            d.ch = {bank, a[1]};
            d.op = a[3:2];
            if (a[7:4] >= 4'h3 && a[7:4] <= 4'h9) begin
                d.tgt = TGT_OP;
                d.idx = 3'(a[7:4] - 4'h3);
            end else if (a[7:4] == 4'hA) begin
                case (a[3:2])
                    2'd0:    d.tgt = TGT_FLO;
                    2'd1:    d.tgt = TGT_FHI;
                    2'd2:    d.tgt = TGT_XLO;
                    default: d.tgt = TGT_XHI;
                endcase
            end else if (a[7:4] == 4'hB && !a[3]) begin
                d.tgt = TGT_CHCFG;
                d.idx = {2'b00, a[2]};
            end
        end
        return d;
    endfunction

    // Channel code of the key register: 1,2 -> ch0,ch1; 5,6 -> ch2,ch3.
    function automatic keysel_t key_channel(input logic [2:0] code);
        keysel_t k;
        k.valid = (code[1:0] == 2'b01) || (code[1:0] == 2'b10);
        k.ch    = {code[2], code[1]};
        return k;
    endfunction

endpackage

// File: rtl/fm_bank_addr.sv
module fm_bank_addr (
    input  logic       clk,
    input  logic       rst,
    input  logic       addr_we,
    input  logic [7:0] wdata,
    output logic [7:0] addr_q
);
    always_ff @(posedge clk) begin
        if (rst)          addr_q <= '0;
        else if (addr_we) addr_q <= wdata;
    end

    // R1: the latch holds between address writes
    assert_addr_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !addr_we |=> $stable(addr_q));
endmodule

// File: rtl/fm_freq_stage.sv
module fm_freq_stage #(
    parameter int FNUM_W = 11,
    parameter int BLK_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hi_we,
    input  logic              lo_we,
    input  logic [7:0]        wdata,
    output logic [FNUM_W-1:0] fnum,
    output logic [BLK_W-1:0]  blk
);
    localparam int HI_FN_W = FNUM_W - 8;
    localparam int HI_W    = HI_FN_W + BLK_W;

    logic [HI_W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            fnum    <= '0;
            blk     <= '0;
        end else begin
            if (hi_we) stage_q <= wdata[HI_W-1:0];
            if (lo_we) begin
                fnum <= {stage_q[HI_FN_W-1:0], wdata};
                blk  <= stage_q[HI_W-1:HI_FN_W];
            end
        end
    end

    // R4: active pitch moves only on a low-byte write
    assert_pitch_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !lo_we |=> ($stable(fnum) && $stable(blk)));
endmodule

// File: rtl/fm_busy_timer.sv
module fm_busy_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (load)        cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    // R8: a data write raises busy on the next cycle
    assert_busy_after_write_R8: assert property (@(posedge clk) disable iff (rst)
        load |=> busy);
    // R8: the count never exceeds its window
    assert_busy_bound_R8: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(CYCLES));
endmodule

// File: rtl/fm_regif.sv
module fm_regif
    import fm_regif_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic                                           clk,
    input  logic                                           rst,
    input  logic                                           bus_wr,
    input  logic [1:0]                                     bus_port,
    input  logic [7:0]                                     bus_wdata,
    output logic [7:0]                                     bus_rdata,
    input  logic [1:0]                                     timer_flags,
    input  logic [7:0]                                     ssg_rdata,
    input  logic [6:0]                                     adpcm_end,
    output logic                                           busy,
    output logic [NUM_CH-1:0][FNUM_W-1:0]                  fnum,
    output logic [NUM_CH-1:0][BLK_W-1:0]                   block,
    output logic [NUM_CH-1:0][FNUM_W-1:0]                  xfnum,
    output logic [NUM_CH-1:0][BLK_W-1:0]                   xblock,
    output logic [NUM_CH-1:0][NUM_OPS-1:0]                 key_on,
    output logic                                           lfo_enable,
    output logic [2:0]                                     lfo_rate,
    output logic [NUM_CH-1:0][1:0][7:0]                    ch_cfg,
    output logic [NUM_CH-1:0][NUM_OPS-1:0][NUM_OPREGS-1:0][7:0] op_cfg
);
    logic [NUM_BANKS-1:0][7:0] addr_q;
    logic [NUM_BANKS-1:0]      data_we;
    dec_t [NUM_BANKS-1:0]      dec;
    dec_t                      act;
    logic                      wr_any;
    keysel_t                   ksel;
    logic [3:0]                lfo_q;

    // Per-bank address latches and decoders
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        fm_bank_addr u_addr (
            .clk     (clk),
            .rst     (rst),
            .addr_we (bus_wr && bus_port == {1'(b), 1'b0}),
            .wdata   (bus_wdata),
            .addr_q  (addr_q[b])
        );
        assign data_we[b] = bus_wr && (bus_port == {1'(b), 1'b1});
        assign dec[b]     = decode_addr(1'(b), addr_q[b]);
    end

    assign wr_any = |data_we;
    assign act    = data_we[1] ? dec[1] : dec[0];
    assign ksel   = key_channel(bus_wdata[2:0]);

    // Staged frequency pairs, main and extra slot, per channel
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        fm_freq_stage #(.FNUM_W(FNUM_W), .BLK_W(BLK_W)) u_main (
            .clk   (clk),
            .rst   (rst),
            .hi_we (wr_any && act.tgt == TGT_FHI && act.ch == CH_W'(c)),
            .lo_we (wr_any && act.tgt == TGT_FLO && act.ch == CH_W'(c)),
            .wdata (bus_wdata),
            .fnum  (fnum[c]),
            .blk   (block[c])
        );
        fm_freq_stage #(.FNUM_W(FNUM_W), .BLK_W(BLK_W)) u_extra (
            .clk   (clk),
            .rst   (rst),
            .hi_we (wr_any && act.tgt == TGT_XHI && act.ch == CH_W'(c)),
            .lo_we (wr_any && act.tgt == TGT_XLO && act.ch == CH_W'(c)),
            .wdata (bus_wdata),
            .fnum  (xfnum[c]),
            .blk   (xblock[c])
        );
    end

    // Shadow register file
    always_ff @(posedge clk) begin
        if (rst) begin
            op_cfg <= '0;
            ch_cfg <= '0;
            key_on <= '0;
            lfo_q  <= '0;
        end else if (wr_any) begin
            case (act.tgt)
                TGT_OP:    op_cfg[act.ch][act.op][act.idx] <= bus_wdata;
                TGT_CHCFG: ch_cfg[act.ch][act.idx[0]] <= bus_wdata;
                TGT_COMMON: begin
                    if (act.idx[0]) begin
                        if (ksel.valid) key_on[ksel.ch] <= bus_wdata[7:4];
                    end else begin
                        lfo_q <= bus_wdata[3:0];
                    end
                end
                default: ;
            endcase
        end
    end

    assign lfo_enable = lfo_q[3];
    assign lfo_rate   = lfo_q[2:0];

    fm_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk  (clk),
        .rst  (rst),
        .load (wr_any),
        .busy (busy)
    );

    // Read map
    always_comb begin
        case (port_e'(bus_port))
            PORT_ADDR0: bus_rdata = {busy, 5'b0, timer_flags[1], timer_flags[0]};
            PORT_DATA0: bus_rdata = ssg_rdata;
            PORT_ADDR1: bus_rdata = {adpcm_end[6], 1'b0, adpcm_end[5:0]};
            default:    bus_rdata = 8'h00;
        endcase
    end

    // R6: key state moves only on a data write
    assert_key_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !wr_any |=> $stable(key_on));
    // R7: oscillator controls move only on a bank 0 data write
    assert_lfo_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !data_we[0] |=> ($stable(lfo_enable) && $stable(lfo_rate)));
    // R10: bank 1 never reaches the key register
    assert_bank1_no_key_R10: assert property (@(posedge clk) disable iff (rst)
        (data_we[1] && !data_we[0]) |=> $stable(key_on));
endmodule

// File: tb/fm_regif_test.sv
module fm_regif_test;
    import fm_regif_pkg::*;

    localparam int BUSY = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_wr = 1'b0;
    logic [1:0] bus_port = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [1:0] timer_flags = 2'b00;
    logic [7:0] ssg_rdata = 8'h00;
    logic [6:0] adpcm_end = 7'h00;
    logic busy;
    logic [NUM_CH-1:0][FNUM_W-1:0] fnum, xfnum;
    logic [NUM_CH-1:0][BLK_W-1:0] block, xblock;
    logic [NUM_CH-1:0][NUM_OPS-1:0] key_on;
    logic lfo_enable;
    logic [2:0] lfo_rate;
    logic [NUM_CH-1:0][1:0][7:0] ch_cfg;
    logic [NUM_CH-1:0][NUM_OPS-1:0][NUM_OPREGS-1:0][7:0] op_cfg;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    fm_regif #(.BUSY_CYCLES(BUSY)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_port(bus_port),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer_flags(timer_flags),
        .ssg_rdata(ssg_rdata), .adpcm_end(adpcm_end), .busy(busy), .fnum(fnum),
        .block(block), .xfnum(xfnum), .xblock(xblock), .key_on(key_on),
        .lfo_enable(lfo_enable), .lfo_rate(lfo_rate), .ch_cfg(ch_cfg), .op_cfg(op_cfg)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // kind: 0 op_cfg, 1 fnum, 2 block, 3 xfnum, 4 key_on, 5 {lfo_enable,lfo_rate}, 6 ch_cfg
    typedef struct packed {
        logic        bank;
        logic [7:0]  addr;
        logic [7:0]  data;
        logic [2:0]  kind;
        logic [1:0]  ch;
        logic [1:0]  op;
        logic [2:0]  idx;
        logic [15:0] expv;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h31, 8'h75, 3'd0, 2'd0, 2'd0, 3'd0, 16'h0075, 4'd3},  // R3
        '{1'b0, 8'h4E, 8'h22, 3'd0, 2'd1, 2'd3, 3'd1, 16'h0022, 4'd2},  // R2
        '{1'b1, 8'h99, 8'h0F, 3'd0, 2'd2, 2'd2, 3'd6, 16'h000F, 4'd2},  // R2
        '{1'b1, 8'hA6, 8'h2D, 3'd1, 2'd3, 2'd0, 3'd0, 16'h0000, 4'd4},  // R4 staged only
        '{1'b1, 8'hA2, 8'h34, 3'd1, 2'd3, 2'd0, 3'd0, 16'h0534, 4'd4},  // R4 commit
        '{1'b1, 8'hA2, 8'h35, 3'd2, 2'd3, 2'd0, 3'd0, 16'h0005, 4'd4},  // R4 stage kept
        '{1'b0, 8'hAD, 8'h13, 3'd3, 2'd0, 2'd0, 3'd0, 16'h0000, 4'd5},  // R5
        '{1'b0, 8'hA9, 8'hFF, 3'd3, 2'd0, 2'd0, 3'd0, 16'h03FF, 4'd5},  // R5
        '{1'b0, 8'hB2, 8'h3A, 3'd6, 2'd1, 2'd0, 3'd0, 16'h003A, 4'd12}, // R12
        '{1'b1, 8'hB5, 8'hC5, 3'd6, 2'd2, 2'd0, 3'd1, 16'h00C5, 4'd12}, // R12
        '{1'b0, 8'h28, 8'hF2, 3'd4, 2'd1, 2'd0, 3'd0, 16'h000F, 4'd6},  // R6
        '{1'b0, 8'h28, 8'h55, 3'd4, 2'd2, 2'd0, 3'd0, 16'h0005, 4'd6},  // R6
        '{1'b0, 8'h28, 8'h03, 3'd4, 2'd1, 2'd0, 3'd0, 16'h000F, 4'd6},  // R6 bad code
        '{1'b0, 8'h22, 8'h0E, 3'd5, 2'd0, 2'd0, 3'd0, 16'h000E, 4'd7},  // R7
        '{1'b1, 8'h22, 8'h00, 3'd5, 2'd0, 2'd0, 3'd0, 16'h000E, 4'd10}, // R10
        '{1'b1, 8'h28, 8'h00, 3'd4, 2'd2, 2'd0, 3'd0, 16'h0005, 4'd10}, // R10
        '{1'b0, 8'hA3, 8'h99, 3'd1, 2'd0, 2'd0, 3'd0, 16'h0000, 4'd10}, // R10
        '{1'b0, 8'hB9, 8'h77, 3'd6, 2'd0, 2'd0, 3'd0, 16'h0000, 4'd10}  // R10
    };

    function automatic logic [15:0] observe(input logic [2:0] kind, input logic [1:0] ch,
                                            input logic [1:0] op, input logic [2:0] idx);
        case (kind)
            3'd0:    return {8'h00, op_cfg[ch][op][idx]};
            3'd1:    return {5'd0, fnum[ch]};
            3'd2:    return {13'd0, block[ch]};
            3'd3:    return {5'd0, xfnum[ch]};
            3'd4:    return {12'd0, key_on[ch]};
            3'd5:    return {12'd0, lfo_enable, lfo_rate};
            default: return {8'h00, ch_cfg[ch][idx[0]]};
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic port_write(input logic [1:0] p, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_port = p; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic reg_write(input logic bank, input logic [7:0] a, input logic [7:0] d);
        port_write({bank, 1'b0}, a);
        port_write({bank, 1'b1}, d);
    endtask

    task automatic read_port(input logic [1:0] p, output logic [7:0] v);
        @(negedge clk);
        bus_port = p;
        #1;
        v = bus_rdata;
    endtask

    task automatic do_reset;
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        logic [7:0] rv;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R11: reset state
        #1;
        check("R11 reset", {fnum, xfnum, block, xblock, key_on, lfo_enable, lfo_rate, busy},
              '0);
        check("R11 reset op/ch", {|op_cfg, |ch_cfg}, 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            reg_write(VECS[i].bank, VECS[i].addr, VECS[i].data);
            checks = checks + 1;
            if (observe(VECS[i].kind, VECS[i].ch, VECS[i].op, VECS[i].idx) !== VECS[i].expv) begin
                errors = errors + 1;
                $display("FAIL R%0d row %0d: actual=%0h expected=%0h", VECS[i].req, i,
                         observe(VECS[i].kind, VECS[i].ch, VECS[i].op, VECS[i].idx),
                         VECS[i].expv);
            end
        end

        // R1: repeated data writes reuse the latched address
        port_write(2'd0, 8'h41);
        port_write(2'd1, 8'h11);
        port_write(2'd1, 8'h12);
        check("R1 reuse", op_cfg[0][0][1], 8'h12);
        // R1: banks keep separate latches
        port_write(2'd2, 8'h4A);
        port_write(2'd0, 8'h45);
        port_write(2'd3, 8'h66);
        check("R1 bank1 latch", op_cfg[3][2][1], 8'h66);
        check("R1 bank0 untouched", op_cfg[0][1][1], 8'h00);

        // R8: busy window
        repeat (BUSY + 2) @(posedge clk);
        #1;
        check("R8 idle", busy, 1'b0);
        reg_write(1'b0, 8'h72, 8'h5A);
        check("R8 busy set", busy, 1'b1);
        repeat (BUSY - 1) @(posedge clk);
        #1;
        check("R8 busy last", busy, 1'b1);
        @(posedge clk); #1;
        check("R8 busy clear", busy, 1'b0);
        // R8: write during busy accepted and restarts count
        port_write(2'd1, 8'hA1);
        repeat (2) @(posedge clk);
        port_write(2'd1, 8'hB2);
        check("R8 write while busy stored", op_cfg[1][0][4], 8'hB2);
        repeat (BUSY - 1) @(posedge clk);
        #1;
        check("R8 restart", busy, 1'b1);
        @(posedge clk); #1;
        check("R8 restart clear", busy, 1'b0);

        // R9: read map
        timer_flags = 2'b10;
        ssg_rdata   = 8'hA5;
        adpcm_end   = 7'h45;
        read_port(2'd0, rv);
        check("R9 status", rv, 8'h02);
        read_port(2'd1, rv);
        check("R9 ssg", rv, 8'hA5);
        read_port(2'd2, rv);
        check("R9 end flags", rv, 8'h85);
        read_port(2'd3, rv);
        check("R9 zero", rv, 8'h00);
        port_write(2'd1, 8'h00);
        read_port(2'd0, rv);
        check("R9 busy bit", rv, 8'h82);

        // R11: reset clears staging too
        reg_write(1'b0, 8'hA5, 8'h3F);
        do_reset();
        reg_write(1'b0, 8'hA1, 8'h01);
        check("R11 stage cleared", {block[0], fnum[0]}, {3'd0, 11'h001});
        check("R11 key cleared", key_on, '0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule